// File: doc/BRIEF.md
# RISC Instruction Word Decoder

This block turns one 32-bit instruction word of a three-format load/store RISC machine into the control bundle an execute stage needs. The three formats are register (three register fields plus a shift amount and a function code), immediate (two register fields and a 16-bit constant) and jump (a 26-bit index). The block covers the integer ALU operations, the immediate ALU operations, word loads and stores, the two compare branches and the four jumps. Multiply and divide encodings are recognised but marked as unsupported.

The decoder is purely combinational. Its outputs follow the `instr` port within the same cycle and hold no state, so no handshake is involved. The word is presented on `instr` and the bundle is read back from the outputs. The results include:

- the raw register indices and the selected write index;
- the ALU operation;
- the operand routing flags;
- the extended immediate;
- the memory enables;
- the branch, jump and link controls;
- the illegal and unsupported flags.

Top module: `risc_instr_decoder`

## Requirements
- R1: `rs_idx`, `rt_idx`, `rd_idx` and `shamt` always equal bits 25:21, 20:16, 15:11 and 10:6 of `instr`, and `jidx` equals bits 25:0, for every word, legal or not.
- R2: With opcode (bits 31:26) zero, the function code (bits 5:0) selects `alu_op`. The mapping is 32→ADD(1), 33→ADDU(2), 34→SUB(3), 35→SUBU(4), 36→AND(5), 37→OR(6), 38→XOR(7), 39→NOR(8), 42→SLT(9) and 43→SLTU(10). The write destination is rd (`dst_sel`=1) and `imm_mode` is 0 with `imm_value` zero.
- R3: Opcodes 8 (ADD), 9 (ADDU), 10 (SLT), 11 (SLTU), 12 (AND), 13 (OR), 14 (XOR) and 15 (LUI, code 14) write to rt (`dst_sel`=2) and set `b_from_imm`.
- R4: For opcodes 8, 9, 10, 11, 4, 5, 0x23 and 0x2B, `imm_mode` is 1 and `imm_value` is the 16-bit field sign-extended.
- R5: For opcodes 12, 13 and 14, `imm_mode` is 2 and `imm_value` is the 16-bit field zero-extended.
- R6: For opcode 15, `imm_mode` is 3 and `imm_value` holds the 16-bit field in bits 31:16 with bits 15:0 zero.
- R7: Function codes 0, 2 and 3 give SLL(11), SRL(12) and SRA(13) with `a_from_rt`=1 and `shamt_from_reg`=0. Function codes 4, 6 and 7 give the same three operations with `a_from_rt`=1 and `shamt_from_reg`=1, meaning the amount is taken from the rs register.
- R8: Opcode 0x23 (load word) sets `mem_rd`, writes rt and uses ADD with an immediate. Opcode 0x2B (store word) sets `mem_wr`, uses ADD with an immediate and writes no register (`dst_sel`=0, `wr_en`=0).
- R9: Opcode 4 sets `br_type`=1 (equal) and opcode 5 sets `br_type`=2 (not equal). Both use ALU SUB, with no immediate operand and no register write.
- R10: Opcode 2 sets `jmp_type`=1 with no write. Opcode 3 sets `jmp_type`=1 and `link`, with destination register 31 (`dst_sel`=3).
- R11: Function code 8 sets `jmp_type`=2 with no write. Function code 9 sets `jmp_type`=2 and `link`, with destination rd.
- R12: Any opcode or function code not named above raises `illegal`. Function codes 24 to 27 (multiply and divide) also raise `muldiv`. An illegal word drives `alu_op`, `dst_sel`, `wr_idx`, `wr_en`, the memory enables, the branch and jump types, `link`, the routing flags and `imm_value` all to zero.
- R13: `wr_idx` is the selected destination index, or 0 when `dst_sel` is 0. `wr_en` is 1 only when a destination is selected and `wr_idx` is nonzero, so a write aimed at register 0 is dropped. The all-zero word is a legal no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word to decode |
| rs_idx | output | 5 | First source register field |
| rt_idx | output | 5 | Second source / immediate-format destination field |
| rd_idx | output | 5 | Register-format destination field |
| shamt | output | 5 | Constant shift amount field |
| jidx | output | 26 | Jump index field |
| dst_sel | output | 2 | Destination choice: 0 none, 1 rd, 2 rt, 3 link register |
| wr_idx | output | 5 | Register index to be written |
| wr_en | output | 1 | Register write enable |
| alu_op | output | 4 | ALU operation code |
| a_from_rt | output | 1 | First ALU operand is taken from rt (shifts) |
| shamt_from_reg | output | 1 | Shift amount comes from the rs register |
| b_from_imm | output | 1 | Second ALU operand is the extended immediate |
| imm_mode | output | 2 | Extension: 0 none, 1 sign, 2 zero, 3 upper |
| imm_value | output | 32 | Extended immediate |
| mem_rd | output | 1 | Word load |
| mem_wr | output | 1 | Word store |
| br_type | output | 2 | 0 none, 1 branch if equal, 2 branch if not equal |
| jmp_type | output | 2 | 0 none, 1 index jump, 2 register jump |
| link | output | 1 | Jump saves its return address |
| illegal | output | 1 | Word is not in the supported subset |
| muldiv | output | 1 | Word is a multiply or divide encoding |

## Verification
The bench presses on the extension boundary. It uses immediates with bit 15 set on both arithmetic and logical opcodes, so a decoder that sign-extends `ori` or zero-extends `addi` shows a wrong upper half. Shift words carry distinct rs and rt values and a nonzero shamt, which exposes a decoder that routes the shifted source from rs or confuses the constant and variable amount. Writes aimed at register 0 are covered by the zero word, by `addi` and by `jalr` with rd 0, any of which would otherwise corrupt the hard-wired zero. The gaps in the function code map (40, 41, the multiply/divide group) and unused opcodes are fed in to catch a decoder that falls through to a legal operation or leaves a write enabled.

// File: rtl/rdec_pkg.sv
package rdec_pkg;

  localparam int unsigned OPC_W  = 6;
  localparam int unsigned REG_W  = 5;
  localparam int unsigned FUNC_W = 6;
  localparam int unsigned IMM_W  = 16;
  localparam int unsigned JIDX_W = 26;
  localparam int unsigned WORD_W = OPC_W + JIDX_W;

  // primary opcodes
  localparam logic [OPC_W-1:0] OP_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OP_J     = 6'h02;
  localparam logic [OPC_W-1:0] OP_JAL   = 6'h03;
  localparam logic [OPC_W-1:0] OP_BEQ   = 6'h04;
  localparam logic [OPC_W-1:0] OP_BNE   = 6'h05;
  localparam logic [OPC_W-1:0] OP_ADDI  = 6'h08;
  localparam logic [OPC_W-1:0] OP_ADDIU = 6'h09;
  localparam logic [OPC_W-1:0] OP_SLTI  = 6'h0A;
  localparam logic [OPC_W-1:0] OP_SLTIU = 6'h0B;
  localparam logic [OPC_W-1:0] OP_ANDI  = 6'h0C;
  localparam logic [OPC_W-1:0] OP_ORI   = 6'h0D;
  localparam logic [OPC_W-1:0] OP_XORI  = 6'h0E;
  localparam logic [OPC_W-1:0] OP_LUI   = 6'h0F;
  localparam logic [OPC_W-1:0] OP_LW    = 6'h23;
  localparam logic [OPC_W-1:0] OP_SW    = 6'h2B;

  // function codes
  localparam logic [FUNC_W-1:0] FN_SLL   = 6'd0;
  localparam logic [FUNC_W-1:0] FN_SRL   = 6'd2;
  localparam logic [FUNC_W-1:0] FN_SRA   = 6'd3;
  localparam logic [FUNC_W-1:0] FN_SLLV  = 6'd4;
  localparam logic [FUNC_W-1:0] FN_SRLV  = 6'd6;
  localparam logic [FUNC_W-1:0] FN_SRAV  = 6'd7;
  localparam logic [FUNC_W-1:0] FN_JR    = 6'd8;
  localparam logic [FUNC_W-1:0] FN_JALR  = 6'd9;
  localparam logic [FUNC_W-1:0] FN_MULT  = 6'd24;
  localparam logic [FUNC_W-1:0] FN_MULTU = 6'd25;
  localparam logic [FUNC_W-1:0] FN_DIV   = 6'd26;
  localparam logic [FUNC_W-1:0] FN_DIVU  = 6'd27;
  localparam logic [FUNC_W-1:0] FN_ADD   = 6'd32;
  localparam logic [FUNC_W-1:0] FN_ADDU  = 6'd33;
  localparam logic [FUNC_W-1:0] FN_SUB   = 6'd34;
  localparam logic [FUNC_W-1:0] FN_SUBU  = 6'd35;
  localparam logic [FUNC_W-1:0] FN_AND   = 6'd36;
  localparam logic [FUNC_W-1:0] FN_OR    = 6'd37;
  localparam logic [FUNC_W-1:0] FN_XOR   = 6'd38;
  localparam logic [FUNC_W-1:0] FN_NOR   = 6'd39;
  localparam logic [FUNC_W-1:0] FN_SLT   = 6'd42;
  localparam logic [FUNC_W-1:0] FN_SLTU  = 6'd43;

  typedef enum logic [3:0] {
    ALU_NOP  = 4'd0,  ALU_ADD  = 4'd1,  ALU_ADDU = 4'd2,  ALU_SUB  = 4'd3,
    ALU_SUBU = 4'd4,  ALU_AND  = 4'd5,  ALU_OR   = 4'd6,  ALU_XOR  = 4'd7,
    ALU_NOR  = 4'd8,  ALU_SLT  = 4'd9,  ALU_SLTU = 4'd10, ALU_SLL  = 4'd11,
    ALU_SRL  = 4'd12, ALU_SRA  = 4'd13, ALU_LUI  = 4'd14
  } alu_op_e;

  typedef enum logic [1:0] {
    IMM_NONE = 2'd0, IMM_SIGN = 2'd1, IMM_ZERO = 2'd2, IMM_UPPER = 2'd3
  } imm_mode_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0, DST_RD = 2'd1, DST_RT = 2'd2, DST_LINK = 2'd3
  } dst_sel_e;

  typedef enum logic [1:0] {
    BR_NONE = 2'd0, BR_EQ = 2'd1, BR_NE = 2'd2
  } br_type_e;

  typedef enum logic [1:0] {
    JMP_NONE = 2'd0, JMP_IDX = 2'd1, JMP_REG = 2'd2
  } jmp_type_e;

  // split fields of one word
  typedef struct packed {
    logic [OPC_W-1:0]  opcode;
    logic [REG_W-1:0]  rs;
    logic [REG_W-1:0]  rt;
    logic [REG_W-1:0]  rd;
    logic [REG_W-1:0]  shamt;
    logic [FUNC_W-1:0] func;
    logic [IMM_W-1:0]  imm;
    logic [JIDX_W-1:0] jidx;
  } ins_fields_t;

  // control produced by either sub-decoder
  typedef struct packed {
    alu_op_e   alu_op;
    imm_mode_e imm_mode;
    dst_sel_e  dst;
    br_type_e  br;
    jmp_type_e jmp;
    logic      a_from_rt;
    logic      shamt_from_reg;
    logic      b_from_imm;
    logic      mem_rd;
    logic      mem_wr;
    logic      link;
    logic      muldiv;
    logic      legal;
  } dec_ctl_t;

endpackage

// File: rtl/rdec_fields.sv
module rdec_fields
  import rdec_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output ins_fields_t       fld
);

  localparam int unsigned OPC_LSB = WORD_W - OPC_W;
  localparam int unsigned RS_LSB  = OPC_LSB - REG_W;
  localparam int unsigned RT_LSB  = RS_LSB - REG_W;
  localparam int unsigned RD_LSB  = RT_LSB - REG_W;
  localparam int unsigned SH_LSB  = RD_LSB - REG_W;

  always_comb begin
    fld.opcode = word[OPC_LSB +: OPC_W];
    fld.rs     = word[RS_LSB  +: REG_W];
    fld.rt     = word[RT_LSB  +: REG_W];
    fld.rd     = word[RD_LSB  +: REG_W];
    fld.shamt  = word[SH_LSB  +: REG_W];
    fld.func   = word[FUNC_W-1:0];
    fld.imm    = word[IMM_W-1:0];
    fld.jidx   = word[JIDX_W-1:0];
  end

endmodule

// File: rtl/rdec_func.sv
module rdec_func
  import rdec_pkg::*;
(
  input  logic [FUNC_W-1:0] func,
  output dec_ctl_t          ctl
);

  always_comb begin
    ctl       = '0;
    ctl.legal = 1'b1;
    case (func)
      FN_SLL, FN_SRL, FN_SRA, FN_SLLV, FN_SRLV, FN_SRAV: begin
        ctl.a_from_rt      = 1'b1;
        ctl.shamt_from_reg = func[2];
        ctl.dst            = DST_RD;
        case (func[1:0])
          2'd0:    ctl.alu_op = ALU_SLL;
          2'd2:    ctl.alu_op = ALU_SRL;
          default: ctl.alu_op = ALU_SRA;
        endcase
      end
      FN_JR: begin
        ctl.jmp = JMP_REG;
      end
      FN_JALR: begin
        ctl.jmp  = JMP_REG;
        ctl.link = 1'b1;
        ctl.dst  = DST_RD;
      end
      FN_MULT, FN_MULTU, FN_DIV, FN_DIVU: begin
        ctl.muldiv = 1'b1;
        ctl.legal  = 1'b0;
      end
      FN_ADD:  begin ctl.alu_op = ALU_ADD;  ctl.dst = DST_RD; end
      FN_ADDU: begin ctl.alu_op = ALU_ADDU; ctl.dst = DST_RD; end
      FN_SUB:  begin ctl.alu_op = ALU_SUB;  ctl.dst = DST_RD; end
      FN_SUBU: begin ctl.alu_op = ALU_SUBU; ctl.dst = DST_RD; end
      FN_AND:  begin ctl.alu_op = ALU_AND;  ctl.dst = DST_RD; end
      FN_OR:   begin ctl.alu_op = ALU_OR;   ctl.dst = DST_RD; end
      FN_XOR:  begin ctl.alu_op = ALU_XOR;  ctl.dst = DST_RD; end
      FN_NOR:  begin ctl.alu_op = ALU_NOR;  ctl.dst = DST_RD; end
      FN_SLT:  begin ctl.alu_op = ALU_SLT;  ctl.dst = DST_RD; end
      FN_SLTU: begin ctl.alu_op = ALU_SLTU; ctl.dst = DST_RD; end
      default: ctl.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/rdec_opcode.sv
module rdec_opcode
  import rdec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output dec_ctl_t         ctl
);

  always_comb begin
    ctl       = '0;
    ctl.legal = 1'b1;
    case (opcode)
      OP_J: begin
        ctl.jmp = JMP_IDX;
      end
      OP_JAL: begin
        ctl.jmp  = JMP_IDX;
        ctl.link = 1'b1;
        ctl.dst  = DST_LINK;
      end
      OP_BEQ, OP_BNE: begin
        ctl.br       = opcode[0] ? BR_NE : BR_EQ;
        ctl.alu_op   = ALU_SUB;
        ctl.imm_mode = IMM_SIGN;
      end
      OP_ADDI, OP_ADDIU, OP_SLTI, OP_SLTIU: begin
        ctl.imm_mode   = IMM_SIGN;
        ctl.b_from_imm = 1'b1;
        ctl.dst        = DST_RT;
        case (opcode[1:0])
          2'd0:    ctl.alu_op = ALU_ADD;
          2'd1:    ctl.alu_op = ALU_ADDU;
          2'd2:    ctl.alu_op = ALU_SLT;
          default: ctl.alu_op = ALU_SLTU;
        endcase
      end
      OP_ANDI, OP_ORI, OP_XORI: begin
        ctl.imm_mode   = IMM_ZERO;
        ctl.b_from_imm = 1'b1;
        ctl.dst        = DST_RT;
        case (opcode[1:0])
          2'd0:    ctl.alu_op = ALU_AND;
          2'd1:    ctl.alu_op = ALU_OR;
          default: ctl.alu_op = ALU_XOR;
        endcase
      end
      OP_LUI: begin
        ctl.imm_mode   = IMM_UPPER;
        ctl.b_from_imm = 1'b1;
        ctl.dst        = DST_RT;
        ctl.alu_op     = ALU_LUI;
      end
      OP_LW: begin
        ctl.imm_mode   = IMM_SIGN;
        ctl.b_from_imm = 1'b1;
        ctl.alu_op     = ALU_ADD;
        ctl.dst        = DST_RT;
        ctl.mem_rd     = 1'b1;
      end
      OP_SW: begin
        ctl.imm_mode   = IMM_SIGN;
        ctl.b_from_imm = 1'b1;
        ctl.alu_op     = ALU_ADD;
        ctl.mem_wr     = 1'b1;
      end
      default: ctl.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/rdec_imm.sv
module rdec_imm
  import rdec_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [IMM_W-1:0] imm,
  input  imm_mode_e        mode,
  output logic [XLEN-1:0]  value
);

  localparam int unsigned PAD = XLEN - IMM_W;

  logic [XLEN-1:0] sext;
  logic [XLEN-1:0] zext;

  assign sext = {{PAD{imm[IMM_W-1]}}, imm};
  assign zext = {{PAD{1'b0}}, imm};

  always_comb begin
    case (mode)
      IMM_SIGN:  value = sext;
      IMM_ZERO:  value = zext;
      IMM_UPPER: value = sext << IMM_W;
      default:   value = '0;
    endcase
  end

endmodule

// File: rtl/risc_instr_decoder.sv
module risc_instr_decoder
  import rdec_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned LINK_REG = 31
) (
  input  logic [31:0]     instr,
  output logic [4:0]      rs_idx,
  output logic [4:0]      rt_idx,
  output logic [4:0]      rd_idx,
  output logic [4:0]      shamt,
  output logic [25:0]     jidx,
  output logic [1:0]      dst_sel,
  output logic [4:0]      wr_idx,
  output logic            wr_en,
  output logic [3:0]      alu_op,
  output logic            a_from_rt,
  output logic            shamt_from_reg,
  output logic            b_from_imm,
  output logic [1:0]      imm_mode,
  output logic [XLEN-1:0] imm_value,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [1:0]      br_type,
  output logic [1:0]      jmp_type,
  output logic            link,
  output logic            illegal,
  output logic            muldiv
);

  localparam logic [REG_W-1:0] LINK_IDX = REG_W'(LINK_REG);

  ins_fields_t fld;
  dec_ctl_t    r_ctl;
  dec_ctl_t    i_ctl;
  dec_ctl_t    ctl;

  rdec_fields u_fields (.word(instr), .fld(fld));
  rdec_func   u_func   (.func(fld.func), .ctl(r_ctl));
  rdec_opcode u_opcode (.opcode(fld.opcode), .ctl(i_ctl));

  assign ctl = (fld.opcode == OP_RTYPE) ? r_ctl : i_ctl;

  rdec_imm #(.XLEN(XLEN)) u_imm (
    .imm   (fld.imm),
    .mode  (ctl.imm_mode),
    .value (imm_value)
  );

  logic [REG_W-1:0] dest;

  always_comb begin
    case (ctl.dst)
      DST_RD:   dest = fld.rd;
      DST_RT:   dest = fld.rt;
      DST_LINK: dest = LINK_IDX;
      default:  dest = '0;
    endcase
  end

  assign rs_idx         = fld.rs;
  assign rt_idx         = fld.rt;
  assign rd_idx         = fld.rd;
  assign shamt          = fld.shamt;
  assign jidx           = fld.jidx;
  assign dst_sel        = ctl.dst;
  assign wr_idx         = dest;
  assign wr_en          = ctl.legal && (ctl.dst != DST_NONE) && (dest != '0);
  assign alu_op         = ctl.alu_op;
  assign a_from_rt      = ctl.a_from_rt;
  assign shamt_from_reg = ctl.shamt_from_reg;
  assign b_from_imm     = ctl.b_from_imm;
  assign imm_mode       = ctl.imm_mode;
  assign mem_rd         = ctl.mem_rd;
  assign mem_wr         = ctl.mem_wr;
  assign br_type        = ctl.br;
  assign jmp_type       = ctl.jmp;
  assign link           = ctl.link;
  assign illegal        = !ctl.legal;
  assign muldiv         = ctl.muldiv;

endmodule

// File: rtl/risc_instr_decoder_chk.sv
module risc_instr_decoder_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic [31:0]     instr,
  input logic [4:0]      wr_idx,
  input logic            wr_en,
  input logic [1:0]      imm_mode,
  input logic [XLEN-1:0] imm_value,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic [1:0]      br_type,
  input logic [1:0]      jmp_type,
  input logic            link,
  input logic            illegal
);

  always_comb begin
    AST_ZERO_DEST_DROPPED: assert (!(instr[31:26] == 6'd0 && instr[15:11] == 5'd0 && wr_en)) else $error("write to r0 enabled"); // R13
    AST_WRITE_NOT_R0: assert (!(wr_en && wr_idx == 5'd0)) else $error("enabled write index zero"); // R13
    AST_ILLEGAL_QUIET: assert (!(illegal && (wr_en || mem_rd || mem_wr || br_type != 2'd0 || jmp_type != 2'd0 || link))) else $error("illegal word has side effect"); // R12
    AST_ONE_CLASS: assert ($onehot0({mem_rd, mem_wr, br_type != 2'd0, jmp_type != 2'd0})) else $error("more than one control class"); // R8
    AST_ZEXT_HIGH_CLEAR: assert (!(imm_mode == 2'd2 && imm_value[XLEN-1:16] != '0)) else $error("zero extension leaked"); // R5
    AST_UPPER_LOW_CLEAR: assert (!(imm_mode == 2'd3 && imm_value[15:0] != 16'd0)) else $error("upper immediate low half nonzero"); // R6
    AST_LINK_NEEDS_JUMP: assert (!(link && jmp_type == 2'd0)) else $error("link without jump"); // R10
  end

endmodule

bind risc_instr_decoder risc_instr_decoder_chk #(.XLEN(XLEN)) chk_i (
  .instr     (instr),
  .wr_idx    (wr_idx),
  .wr_en     (wr_en),
  .imm_mode  (imm_mode),
  .imm_value (imm_value),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .br_type   (br_type),
  .jmp_type  (jmp_type),
  .link      (link),
  .illegal   (illegal)
);

// File: tb/risc_instr_decoder_tb_top.sv
`timescale 1ns/1ps
module risc_instr_decoder_tb_top;

  typedef struct packed {
    logic [4:0]  rs, rt, rd, sh;
    logic [25:0] jidx;
    logic [1:0]  dst;
    logic [4:0]  widx;
    logic        wen;
    logic [3:0]  alu;
    logic        a_rt, sh_reg, b_imm;
    logic [1:0]  imode;
    logic [31:0] ival;
    logic        mrd, mwr;
    logic [1:0]  br, jmp;
    logic        lnk, ill, md;
  } vec_t;

  typedef struct {
    logic [31:0] w;
    vec_t        exp;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] instr = 32'd0;
  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;
  item_t sb_q[$];

  always #10 clk = ~clk;

  logic [4:0] rs_idx, rt_idx, rd_idx, shamt, wr_idx;
  logic [25:0] jidx;
  logic [1:0] dst_sel, imm_mode, br_type, jmp_type;
  logic wr_en, a_from_rt, shamt_from_reg, b_from_imm, mem_rd, mem_wr, link, illegal, muldiv;
  logic [3:0] alu_op;
  logic [31:0] imm_value;

  risc_instr_decoder dut_i (
    .instr(instr), .rs_idx(rs_idx), .rt_idx(rt_idx), .rd_idx(rd_idx), .shamt(shamt),
    .jidx(jidx), .dst_sel(dst_sel), .wr_idx(wr_idx), .wr_en(wr_en), .alu_op(alu_op),
    .a_from_rt(a_from_rt), .shamt_from_reg(shamt_from_reg), .b_from_imm(b_from_imm),
    .imm_mode(imm_mode), .imm_value(imm_value), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .br_type(br_type), .jmp_type(jmp_type), .link(link), .illegal(illegal), .muldiv(muldiv)
  );

  // reference model written from the requirement list
  function automatic vec_t model(input logic [31:0] w);
    vec_t e;
    logic [5:0] op, fn;
    logic [31:0] sx, zx;
    e = '0;
    op = w[31:26]; fn = w[5:0];
    e.rs = w[25:21]; e.rt = w[20:16]; e.rd = w[15:11]; e.sh = w[10:6]; e.jidx = w[25:0];
    sx = {{16{w[15]}}, w[15:0]};
    zx = {16'd0, w[15:0]};
    if (op == 6'd0) begin
      case (fn)
        6'd0: begin e.alu = 4'd11; e.a_rt = 1; e.dst = 2'd1; end
        6'd2: begin e.alu = 4'd12; e.a_rt = 1; e.dst = 2'd1; end
        6'd3: begin e.alu = 4'd13; e.a_rt = 1; e.dst = 2'd1; end
        6'd4: begin e.alu = 4'd11; e.a_rt = 1; e.sh_reg = 1; e.dst = 2'd1; end
        6'd6: begin e.alu = 4'd12; e.a_rt = 1; e.sh_reg = 1; e.dst = 2'd1; end
        6'd7: begin e.alu = 4'd13; e.a_rt = 1; e.sh_reg = 1; e.dst = 2'd1; end
        6'd8: e.jmp = 2'd2;
        6'd9: begin e.jmp = 2'd2; e.lnk = 1; e.dst = 2'd1; end
        6'd24, 6'd25, 6'd26, 6'd27: begin e.ill = 1; e.md = 1; end
        6'd32: begin e.alu = 4'd1;  e.dst = 2'd1; end
        6'd33: begin e.alu = 4'd2;  e.dst = 2'd1; end
        6'd34: begin e.alu = 4'd3;  e.dst = 2'd1; end
        6'd35: begin e.alu = 4'd4;  e.dst = 2'd1; end
        6'd36: begin e.alu = 4'd5;  e.dst = 2'd1; end
        6'd37: begin e.alu = 4'd6;  e.dst = 2'd1; end
        6'd38: begin e.alu = 4'd7;  e.dst = 2'd1; end
        6'd39: begin e.alu = 4'd8;  e.dst = 2'd1; end
        6'd42: begin e.alu = 4'd9;  e.dst = 2'd1; end
        6'd43: begin e.alu = 4'd10; e.dst = 2'd1; end
        default: e.ill = 1;
      endcase
    end else begin
      case (op)
        6'd2:  e.jmp = 2'd1;
        6'd3:  begin e.jmp = 2'd1; e.lnk = 1; e.dst = 2'd3; end
        6'd4:  begin e.br = 2'd1; e.alu = 4'd3; e.imode = 2'd1; e.ival = sx; end
        6'd5:  begin e.br = 2'd2; e.alu = 4'd3; e.imode = 2'd1; e.ival = sx; end
        6'd8:  begin e.alu = 4'd1;  e.imode = 2'd1; e.ival = sx; e.b_imm = 1; e.dst = 2'd2; end
        6'd9:  begin e.alu = 4'd2;  e.imode = 2'd1; e.ival = sx; e.b_imm = 1; e.dst = 2'd2; end
        6'd10: begin e.alu = 4'd9;  e.imode = 2'd1; e.ival = sx; e.b_imm = 1; e.dst = 2'd2; end
        6'd11: begin e.alu = 4'd10; e.imode = 2'd1; e.ival = sx; e.b_imm = 1; e.dst = 2'd2; end
        6'd12: begin e.alu = 4'd5;  e.imode = 2'd2; e.ival = zx; e.b_imm = 1; e.dst = 2'd2; end
        6'd13: begin e.alu = 4'd6;  e.imode = 2'd2; e.ival = zx; e.b_imm = 1; e.dst = 2'd2; end
        6'd14: begin e.alu = 4'd7;  e.imode = 2'd2; e.ival = zx; e.b_imm = 1; e.dst = 2'd2; end
        6'd15: begin e.alu = 4'd14; e.imode = 2'd3; e.ival = {w[15:0], 16'd0}; e.b_imm = 1; e.dst = 2'd2; end
        6'h23: begin e.alu = 4'd1; e.imode = 2'd1; e.ival = sx; e.b_imm = 1; e.dst = 2'd2; e.mrd = 1; end
        6'h2B: begin e.alu = 4'd1; e.imode = 2'd1; e.ival = sx; e.b_imm = 1; e.mwr = 1; end
        default: e.ill = 1;
      endcase
    end
    case (e.dst)
      2'd1: e.widx = e.rd;
      2'd2: e.widx = e.rt;
      2'd3: e.widx = 5'd31;
      default: e.widx = 5'd0;
    endcase
    e.wen = (e.dst != 2'd0) && (e.widx != 5'd0);
    return e;
  endfunction

  function automatic logic [31:0] rw(input logic [5:0] fn, input logic [4:0] s, input logic [4:0] t,
                                     input logic [4:0] d, input logic [4:0] a);
    return {6'd0, s, t, d, a, fn};
  endfunction

  function automatic logic [31:0] iw(input logic [5:0] op, input logic [4:0] s, input logic [4:0] t,
                                     input logic [15:0] k);
    return {op, s, t, k};
  endfunction

  // driver: apply a word after the edge and queue its expectation
  task automatic drive(input logic [31:0] w, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    instr = w;
    it.w = w; it.exp = model(w); it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: compare mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && sb_q.size() > 0) begin
        item_t it;
        vec_t act;
        it = sb_q.pop_front();
        act = {rs_idx, rt_idx, rd_idx, shamt, jidx, dst_sel, wr_idx, wr_en, alu_op,
               a_from_rt, shamt_from_reg, b_from_imm, imm_mode, imm_value, mem_rd, mem_wr,
               br_type, jmp_type, link, illegal, muldiv};
        n_checks++;
        if (act !== it.exp) begin
          n_errors++;
          $display("FAIL %s instr=%h actual=%h expected=%h", it.tag, it.w, act, it.exp);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] x;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    drive(32'd0, "R13 reset no-op word");
    drive(rw(6'd32, 5'd11, 5'd9, 5'd10, 5'd0), "R2 add");
    for (int f = 32; f < 44; f++) drive(rw(6'(f), 5'd3, 5'd4, 5'd5, 5'd0), "R2/R12 func sweep");
    drive(rw(6'd0, 5'd7, 5'd2, 5'd2, 5'd4), "R7 sll constant");
    drive(rw(6'd2, 5'd7, 5'd2, 5'd6, 5'd31), "R7 srl constant");
    drive(rw(6'd3, 5'd7, 5'd2, 5'd6, 5'd1), "R7 sra constant");
    drive(rw(6'd4, 5'd8, 5'd2, 5'd2, 5'd0), "R7 sllv");
    drive(rw(6'd6, 5'd8, 5'd2, 5'd9, 5'd0), "R7 srlv");
    drive(rw(6'd7, 5'd8, 5'd2, 5'd9, 5'd0), "R7 srav");
    drive(iw(6'd8, 5'd11, 5'd9, 16'hFFFD), "R3 R4 addi negative");
    drive(iw(6'd9, 5'd1, 5'd2, 16'h7FFF), "R3 R4 addiu positive");
    drive(iw(6'd10, 5'd18, 5'd8, 16'h8000), "R3 R4 slti");
    drive(iw(6'd11, 5'd18, 5'd8, 16'hFFFF), "R3 R4 sltiu");
    drive(iw(6'd12, 5'd29, 5'd29, 16'h8001), "R5 andi high bit");
    drive(iw(6'd13, 5'd8, 5'd8, 16'hAAAA), "R5 ori");
    drive(iw(6'd14, 5'd8, 5'd9, 16'hFFFF), "R5 xori");
    drive(iw(6'd15, 5'd0, 5'd8, 16'hAAAA), "R6 lui");
    drive(iw(6'h23, 5'd0, 5'd8, 16'h1008), "R8 lw");
    drive(iw(6'h23, 5'd4, 5'd8, 16'hFFFC), "R8 R4 lw negative offset");
    drive(iw(6'h2B, 5'd4, 5'd8, 16'h100C), "R8 sw");
    drive(iw(6'd4, 5'd9, 5'd0, 16'hFFFE), "R9 beq");
    drive(iw(6'd5, 5'd9, 5'd10, 16'h0019), "R9 bne");
    drive({6'd2, 26'h3FF_FFFF}, "R10 j");
    drive({6'd3, 26'h000_09C4}, "R10 jal");
    drive(rw(6'd8, 5'd8, 5'd0, 5'd0, 5'd0), "R11 jr");
    drive(rw(6'd9, 5'd8, 5'd0, 5'd31, 5'd0), "R11 jalr");
    drive(rw(6'd9, 5'd8, 5'd0, 5'd0, 5'd0), "R11 R13 jalr to r0");
    drive(iw(6'd8, 5'd3, 5'd0, 16'd5), "R13 addi to r0");
    drive(rw(6'd32, 5'd3, 5'd4, 5'd0, 5'd0), "R13 add to r0");
    for (int f = 24; f < 28; f++) drive(rw(6'(f), 5'd4, 5'd5, 5'd0, 5'd0), "R12 multiply/divide");
    drive(iw(6'd1, 5'd1, 5'd2, 16'h1234), "R12 opcode 1");
    drive(iw(6'h3F, 5'd1, 5'd2, 16'h1234), "R12 opcode 3F");
    drive(rw(6'd1, 5'd1, 5'd2, 5'd3, 5'd0), "R12 func 1");
    drive(rw(6'd5, 5'd1, 5'd2, 5'd3, 5'd0), "R12 func 5");
    x = 32'hACE1_1357;
    for (int i = 0; i < 160; i++) begin
      x = {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
      drive(x, "R1 field split / mixed words");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule